// File: doc/BRIEF.md
# Flag-Alternating Three-Stage Word Link

This block models, on one shared clock, a link made of three stages that each advance only on their own enable pulse: a writer, a bus and a reader. The enables stand in for three independent, roughly periodic device clocks. The writer registers each new data word together with a one-bit marker that flips on every write. The bus copies the writer's register into the reader's input register whenever it ticks, and the input register keeps its value between bus ticks. The reader loads that input register on its own ticks and hands a word to the output only when the marker differs from the one it loaded on its previous tick.

There is no acknowledge path back to the writer. Delivery relies only on the marker changing. When the writer period is at least the bus period, and the whole number of bus periods per writer period is at least the reader period divided by the bus period, every written word reaches the output exactly once and in order. Each delivery is flagged by a one-cycle valid strobe.

Top module: `ltt_link`

## Requirements
- R1: Every writer tick stores the input word with a marker that is the inverse of the previously stored marker. The stored marker is true after reset, so the first word written carries marker false.
- R2: The writer register changes only on a writer tick. In any other cycle it keeps the word and marker of the most recent writer tick.
- R3: On a bus tick the reader input register takes the writer register's value. Between bus ticks it holds its last value.
- R4: On a reader tick the reader loads its input register. If the loaded marker differs from the marker it loaded on its previous tick, `word_out` shows the loaded word and `word_vld` is high during the cycle that follows the tick edge. `word_vld` is never high in a cycle that does not follow a reader tick.
- R5: A reader tick that loads the same marker as the previous reader tick raises no `word_vld`.
- R6: If the same data value is written on two successive writer ticks, it is delivered twice.
- R7: The reader's remembered marker starts at true, so the first word written after reset is delivered.
- R8: Synchronous active-high reset clears both data registers and `word_out` to zero. It sets both stored markers and the reader's remembered marker to true, sets the writer's next marker to false, and deasserts `word_vld` in the cycle after reset. A word in flight before reset is not delivered afterwards.
- R9: When enables coincide in one cycle, each stage samples the values from before that cycle's updates. A written word therefore needs a later bus tick and then a later reader tick to appear.
- R10: Under the period condition in the description, the sequence of delivered words equals the sequence of written words, with none lost and none duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_tick | input | 1 | Writer enable pulse |
| wr_word | input | DATA_W | Word to write on a writer tick |
| bus_tick | input | 1 | Bus enable pulse |
| rd_tick | input | 1 | Reader enable pulse |
| word_out | output | DATA_W | Last delivered word |
| word_vld | output | 1 | One-cycle strobe marking a delivery |

## Verification
A marker that is stuck or flips twice in the writer shows at the ports as a lost or repeated word. This appears at the first reader tick that follows the next bus tick, which is about one writer period later. A bus or reader register that updates outside its own tick shows up as a word arriving one stage too early, at the earliest strobe after that stimulus. A wrong reset value of a remembered marker shows as a missing or spurious first delivery after reset. For these reasons the directed table checks the exact strobe cycle, and the periodic runs compare whole delivered sequences against the written ones.

// File: rtl/ltt_pkg.sv
package ltt_pkg;
    // Reset values of the alternating markers
    localparam logic HELD_MARK_RST = 1'b1;  // marker held in writer/bus registers
    localparam logic NEXT_MARK_RST = 1'b0;  // marker attached to the first write
    localparam logic LAST_MARK_RST = 1'b1;  // reader's remembered marker

    // A new word is present when the marker moved since the previous sample
    function automatic logic mark_moved(input logic now_mark, input logic last_mark);
        return now_mark ^ last_mark;
    endfunction

    // Next marker in the alternating sequence
    function automatic logic mark_step(input logic cur);
        return ~cur;
    endfunction
endpackage

// File: rtl/ltt_writer.sv
module ltt_writer
    import ltt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] held_data,
    output logic              held_mark
);
    typedef struct packed {
        logic              mark;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_q;
    logic  next_mark_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q      <= '{mark: HELD_MARK_RST, data: '0};
            next_mark_q <= NEXT_MARK_RST;
        end else if (tick) begin
            slot_q      <= '{mark: next_mark_q, data: din};
            next_mark_q <= mark_step(next_mark_q);
        end
    end

    assign held_data = slot_q.data;
    assign held_mark = slot_q.mark;

    // R1: every write flips the held marker
    p_mark_flips_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> held_mark != $past(held_mark));
    // R1: a write stores the input word
    p_word_taken_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> held_data == $past(din));
    // R2: no write, no change
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(held_data) && $stable(held_mark));
endmodule

// File: rtl/ltt_bus.sv
module ltt_bus
    import ltt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_mark,
    output logic [DATA_W-1:0] dst_data,
    output logic              dst_mark
);
    typedef struct packed {
        logic              mark;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst)
            slot_q <= '{mark: HELD_MARK_RST, data: '0};
        else if (tick)
            slot_q <= '{mark: src_mark, data: src_data};
    end

    assign dst_data = slot_q.data;
    assign dst_mark = slot_q.mark;

    // R3: a bus tick copies the pre-edge writer register
    p_copy_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> dst_data == $past(src_data) && dst_mark == $past(src_mark));
    // R3: between ticks the reader input register holds
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(dst_data) && $stable(dst_mark));
endmodule

// File: rtl/ltt_reader.sv
module ltt_reader
    import ltt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_mark,
    output logic [DATA_W-1:0] out_data,
    output logic              out_vld
);
    logic              last_mark_q;
    logic [DATA_W-1:0] out_q;
    logic              vld_q;
    logic              fresh;

    assign fresh = mark_moved(in_mark, last_mark_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_mark_q <= LAST_MARK_RST;
            out_q       <= '0;
            vld_q       <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (tick) begin
                last_mark_q <= in_mark;
                if (fresh) begin
                    out_q <= in_data;
                    vld_q <= 1'b1;
                end
            end
        end
    end

    assign out_data = out_q;
    assign out_vld  = vld_q;

    // R4: strobe only after a reader tick
    p_vld_after_tick_r4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !out_vld);
    // R4: delivered word is what the input register held at the tick
    p_word_match_r4: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> out_data == $past(in_data));
    // R5: two strobes in a row need the input marker to have moved
    p_no_repeat_r5: assert property (@(posedge clk) disable iff (rst)
        out_vld && $past(out_vld) |-> $past(in_mark) != $past(in_mark, 2));
    // R8: reset silences the output
    p_reset_r8: assert property (@(posedge clk)
        rst |=> !out_vld && out_data == '0);
endmodule

// File: rtl/ltt_link.sv
module ltt_link #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_tick,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              bus_tick,
    input  logic              rd_tick,
    output logic [DATA_W-1:0] word_out,
    output logic              word_vld
);
    logic [DATA_W-1:0] w_data, b_data;
    logic              w_mark, b_mark;

    ltt_writer #(.DATA_W(DATA_W)) u_writer (
        .clk(clk), .rst(rst), .tick(wr_tick), .din(wr_word),
        .held_data(w_data), .held_mark(w_mark)
    );

    ltt_bus #(.DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst(rst), .tick(bus_tick),
        .src_data(w_data), .src_mark(w_mark),
        .dst_data(b_data), .dst_mark(b_mark)
    );

    ltt_reader #(.DATA_W(DATA_W)) u_reader (
        .clk(clk), .rst(rst), .tick(rd_tick),
        .in_data(b_data), .in_mark(b_mark),
        .out_data(word_out), .out_vld(word_vld)
    );

    // R9: a strobe cannot follow a write in the very same cycle path
    p_stage_delay_r9: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> $past(rd_tick));
endmodule

// File: tb/tb_ltt_link.sv
module tb_ltt_link;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_tick = 1'b0, bus_tick = 1'b0, rd_tick = 1'b0;
    logic [DW-1:0] wr_word = '0;
    logic [DW-1:0] word_out;
    logic          word_vld;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #4 clk = ~clk;  // 125 MHz

    ltt_link #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .wr_tick(wr_tick), .wr_word(wr_word),
        .bus_tick(bus_tick), .rd_tick(rd_tick),
        .word_out(word_out), .word_vld(word_vld)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic b, input logic r, input logic [DW-1:0] d);
        wr_tick = w; bus_tick = b; rd_tick = r; wr_word = d;
        @(negedge clk);
        wr_tick = 0; bus_tick = 0; rd_tick = 0;
    endtask

    typedef struct packed {
        logic          w, b, r;
        logic [DW-1:0] din;
        logic          ev;
        logic [DW-1:0] ed;
    } vec_t;

    // Each step: enables/data for one cycle, strobe expected one edge later
    localparam vec_t VECS [12] = '{
        '{1'b1, 1'b0, 1'b0, 8'hA1, 1'b0, 8'h00},  // write A1, marker false (R1)
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00},  // read reset marker: silent (R7 setup)
        '{1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00},  // bus carries A1 (R3)
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 8'hA1},  // first word delivered (R7, R4)
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00},  // same marker again (R5)
        '{1'b1, 1'b1, 1'b1, 8'hA1, 1'b0, 8'h00},  // all coincide, old values used (R9)
        '{1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00},  // reader sees old bus value (R9)
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 8'hA1},  // repeated value delivered again (R6)
        '{1'b1, 1'b0, 1'b0, 8'hB2, 1'b0, 8'h00},  // write B2
        '{1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},  // idle: writer holds (R2)
        '{1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00},  // reader still sees A1 (R9)
        '{1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 8'hB2}   // B2 delivered (R4)
    };

    task automatic periodic_run(input int wp, input int bp, input int rp, input int nwords);
        logic [DW-1:0] q[$];
        int wo = $urandom_range(wp - 1);
        int bo = $urandom_range(bp - 1);
        int ro = $urandom_range(rp - 1);
        int written = 0;
        int t = 0;
        int tail = 0;
        while (tail < 4 * (wp + bp + rp)) begin
            // observe result of previous edge
            if (word_vld) begin
                if (q.size() == 0)
                    check(1'b0, "R10 duplicate/extra word", word_out, 0);
                else begin
                    logic [DW-1:0] e = q.pop_front();
                    check(word_out == e, "R10 delivered order", word_out, e);
                end
            end
            wr_tick  = (written < nwords) && ((t % wp) == wo);
            bus_tick = ((t % bp) == bo);
            rd_tick  = ((t % rp) == ro);
            wr_word  = DW'($urandom);
            if (wr_tick) begin
                q.push_back(wr_word);
                written++;
            end
            if (written >= nwords && !wr_tick) tail++;
            t++;
            @(negedge clk);
        end
        wr_tick = 0; bus_tick = 0; rd_tick = 0;
        if (word_vld) check(1'b0, "R10 late strobe", word_out, 0);
        check(q.size() == 0, "R10 no word lost", q.size(), 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(word_vld == 1'b0, "R8 reset valid", word_vld, 0);
        check(word_out == '0, "R8 reset word", word_out, 0);
        rst = 1'b0;

        // Directed table
        foreach (VECS[i]) begin
            drive(VECS[i].w, VECS[i].b, VECS[i].r, VECS[i].din);
            check(word_vld == VECS[i].ev, $sformatf("R4 step %0d valid", i), word_vld, VECS[i].ev);
            if (VECS[i].ev)
                check(word_out == VECS[i].ed, $sformatf("R4 step %0d word", i), word_out, VECS[i].ed);
        end

        // R8: word in flight is dropped by reset
        drive(1, 0, 0, 8'h5C);
        drive(0, 1, 0, 8'h00);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(word_vld == 1'b0 && word_out == '0, "R8 after reset", word_out, 0);
        drive(0, 0, 1, 8'h00);
        check(word_vld == 1'b0, "R8 in-flight word dropped", word_vld, 0);
        drive(0, 1, 1, 8'h00);
        check(word_vld == 1'b0, "R8 no delivery from cleared bus", word_vld, 0);

        // R7: first word after reset goes through; R9: needs separate cycles
        drive(1, 1, 1, 8'h3E);
        check(word_vld == 1'b0, "R9 no same-cycle pass", word_vld, 0);
        drive(0, 1, 1, 8'h00);
        check(word_vld == 1'b0, "R9 reader one stage behind", word_vld, 0);
        drive(0, 0, 1, 8'h00);
        check(word_vld == 1'b1 && word_out == 8'h3E, "R7 first word after reset", word_out, 8'h3E);
        drive(0, 0, 0, 8'h00);
        check(word_vld == 1'b0, "R4 strobe is one cycle", word_vld, 0);

        // R10: periodic enables meeting the period condition
        periodic_run(6, 2, 3, 40);
        periodic_run(4, 1, 3, 40);
        periodic_run(7, 3, 2, 40);
        periodic_run(5, 2, 3, 40);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule